// File: doc/BRIEF.md
# Prescaled Countdown Timer

A 32-bit down-counter behind a four-register bus with single-cycle writes and combinational reads. Software programs a start value, picks a prescale factor and turns the counter on. The counter then steps down once for every P+1 cycles in which the peripheral tick enable is high. When it steps from one to zero, a sticky event flag is set. Software clears that flag by writing a one to it. The counter can reload itself from the stored start value to give a periodic tick, or it can stay at zero until software programs it again.

A level interrupt is driven from the event flag, gated by an interrupt-enable bit. Software reads the live count at any time. Writing the start value also restarts the count and the prescaler phase, so that a new interval starts at once.

Top module: `pdown_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register offsets are decoded from `bus_addr[3:2]`: 0x00 start value, 0x04 live count, 0x08 control, 0x0C status. Address bits 1:0 are ignored.
- R3: A write to 0x00 sets both the stored start value and the live count from `bus_wdata` at the same clock edge. It also returns the prescaler phase to zero, and no decrement happens on that edge.
- R4: The live count register is read-only. A write to 0x04 changes neither the count nor the start value.
- R5: Control layout: bit 0 run, bit 1 auto-reload, bit 2 interrupt enable, bits 15:8 prescale P. All other control bits read as 0.
- R6: While run is set, the count steps once for every P+1 cycles with `tick_en` high, and cycles with `tick_en` low are not counted. After run is enabled with count N, the event appears after exactly N*(P+1) ticks.
- R7: While run is clear, the count holds its value whatever `tick_en` does.
- R8: Status bit 0 is set on the step from 1 to 0. It stays set until a write to 0x0C with bit 0 = 1, and writing 0 there has no effect. If a set and a clear fall on the same edge, the set wins.
- R9: With auto-reload set, a step taken at count 0 loads the start value. The count sequence therefore repeats every start+1 steps.
- R10: With auto-reload clear, the count stays at 0 after expiring.
- R11: `irq` is high exactly when status bit 0 and interrupt enable are both set.
- R12: If P is lowered below the current prescaler phase, the next tick causes a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler input qualifier, one tick per high cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The expiry time is swept over every prescale value from 0 to 7 and start values from 1 to 4, with `tick_en` held high. This tells a divide-by-P+1 counter apart from divide-by-P and off-by-one expiry. A pseudo-random `tick_en` pattern checks that only qualified cycles count. Reload runs compare the count at every cycle against a modular sequence, which exposes a wrong reload point or period. Directed patterns cover the cases that a sweep cannot reach: a restart in the middle of a count, a prescale lowered below the current phase, a set and clear of the event on the same edge, and writes to the read-only count.

// File: rtl/pdown_timer.sv
module pdown_timer #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int PRESC_LSB = 8;
  localparam logic [1:0] SEL_LOAD = 2'd0, SEL_CNT = 2'd1, SEL_CTRL = 2'd2, SEL_STAT = 2'd3;

  logic [DATA_W-1:0]  load_q, count_q;
  logic [PRESC_W-1:0] presc_q, phase_q;
  logic               run_q, reload_q, ie_q, evt_q;

  logic [1:0] sel;
  logic       wr_load, wr_ctrl, wr_stat, step, expire;
  logic       unused_bits;

  assign sel     = bus_addr[3:2];
  assign wr_load = bus_we && (sel == SEL_LOAD);
  assign wr_ctrl = bus_we && (sel == SEL_CTRL);
  assign wr_stat = bus_we && (sel == SEL_STAT);
  assign step    = run_q && tick_en && (phase_q >= presc_q);
  assign expire  = step && !wr_load && (count_q == DATA_W'(1));
  assign irq     = evt_q && ie_q;
  assign unused_bits = ^{bus_addr, bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase_q <= '0;
    else if (wr_load || !run_q) phase_q <= '0;
    else if (tick_en)           phase_q <= step ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
    end else if (wr_load) begin
      load_q  <= bus_wdata;
      count_q <= bus_wdata;
    end else if (step) begin
      if (count_q != '0)  count_q <= count_q - 1'b1;
      else if (reload_q)  count_q <= load_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      reload_q <= 1'b0;
      ie_q     <= 1'b0;
      presc_q  <= '0;
    end else if (wr_ctrl) begin
      run_q    <= bus_wdata[0];
      reload_q <= bus_wdata[1];
      ie_q     <= bus_wdata[2];
      presc_q  <= bus_wdata[PRESC_LSB +: PRESC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       evt_q <= 1'b0;
    else if (expire)                  evt_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) evt_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_LOAD: bus_rdata = load_q;
      SEL_CNT:  bus_rdata = count_q;
      SEL_CTRL: begin
        bus_rdata[0] = run_q;
        bus_rdata[1] = reload_q;
        bus_rdata[2] = ie_q;
        bus_rdata[PRESC_LSB +: PRESC_W] = presc_q;
      end
      default:  bus_rdata[0] = evt_q;
    endcase
  end
endmodule

// File: rtl/pdown_timer_chk.sv
module pdown_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load,
  input logic              run,
  input logic              reload,
  input logic              ie,
  input logic              evt
);
  logic load_wr, stat_clr;
  assign load_wr  = bus_we && (bus_addr[3:2] == 2'd0);
  assign stat_clr = bus_we && (bus_addr[3:2] == 2'd3) && bus_wdata[0];

  // R3
  load_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (count == $past(bus_wdata)) && (load == $past(bus_wdata)));

  // R4
  step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_wr |=> (count == $past(count)) || (count == $past(count) - 1'b1) || (count == $past(load)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_wr) |=> $stable(count));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !stat_clr) |=> evt);

  // R8
  clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt) |-> $past(stat_clr));

  // R10
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && count == '0 && !load_wr) |=> count == '0);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> evt);
endmodule

bind pdown_timer pdown_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq(irq), .count(count_q), .load(load_q),
  .run(run_q), .reload(reload_q), .ie(ie_q), .evt(evt_q)
);

// File: tb/pdown_timer_tb.sv
module pdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  lf;
    int seen, ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    wr(4'h0, 32'h1234_5678);
    rd(4'h0, v); check("R3 load readback", v, 32'h1234_5678);
    rd(4'h4, v); check("R3 count follows load", v, 32'h1234_5678);
    rd(4'h1, v); check("R2 low address bits ignored", v, 32'h1234_5678);
    wr(4'h4, 32'hDEAD_BEEF);
    rd(4'h4, v); check("R4 count write ignored", v, 32'h1234_5678);
    rd(4'h0, v); check("R4 load untouched", v, 32'h1234_5678);

    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); check("R5 control layout", v, 32'h0000_FF07);
    wr(4'h8, 32'h0);

    wr(4'h0, 32'd5);
    repeat (10) @(negedge clk);
    rd(4'h4, v); check("R7 disabled hold", v, 32'd5);

    for (int p = 0; p < 8; p++) begin
      for (int n = 1; n <= 4; n++) begin
        wr(4'h0, 32'(n));
        wr(4'hC, 32'h1);
        wr(4'h8, 32'(p << 8) | 32'h1);
        seen = 0;
        for (int k = 1; k <= 200; k++) begin
          @(negedge clk);
          rd(4'hC, v);
          if (v[0]) begin seen = k; break; end
        end
        check("R6 expiry cycles", 32'(seen), 32'(n * (p + 1)));
        wr(4'h8, 32'h0);
      end
    end
    rd(4'h4, v); check("R10 parked at zero", v, 32'h0);

    wr(4'h0, 32'd3);
    wr(4'hC, 32'h1);
    tick_en = 1'b0;
    wr(4'h8, 32'h0201);
    lf = 8'hA5;
    tick_en = lf[0];
    ticks = 0; seen = 0;
    for (int k = 1; k <= 500; k++) begin
      ticks += int'(tick_en);
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tick_en = lf[0];
      rd(4'hC, v);
      if (v[0]) begin seen = ticks; break; end
    end
    tick_en = 1'b1;
    check("R6 gated ticks to expiry", 32'(seen), 32'd9);
    wr(4'h8, 32'h0);

    for (int c = 0; c < 2; c++) begin
      int n, p, e;
      n = (c == 0) ? 3 : 2;
      p = (c == 0) ? 0 : 2;
      wr(4'h0, 32'(n));
      wr(4'h8, 32'(p << 8) | 32'h3);
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        e = (n - k / (p + 1)) % (n + 1);
        if (e < 0) e += n + 1;
        rd(4'h4, v);
        check("R9 reload sequence", v, 32'(e));
      end
      wr(4'h8, 32'h0);
    end

    wr(4'hC, 32'h0);
    rd(4'hC, v); check("R8 write zero keeps flag", v, 32'h1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); check("R8 write one clears", v, 32'h0);

    wr(4'h0, 32'd2);
    wr(4'h8, 32'h1);
    @(negedge clk);
    wr(4'hC, 32'h1);
    rd(4'hC, v); check("R8 set beats clear", v, 32'h1);
    repeat (5) @(negedge clk);
    rd(4'h4, v); check("R10 no reload stays zero", v, 32'h0);

    check("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(4'h8, 32'h5);
    check("R11 irq asserted", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h1);
    check("R11 irq dropped on clear", {31'b0, irq}, 32'h0);

    wr(4'h8, 32'h0);
    wr(4'h0, 32'd100);
    wr(4'h8, 32'h0301);
    repeat (2) @(negedge clk);
    wr(4'h0, 32'd7);
    repeat (3) @(negedge clk);
    rd(4'h4, v); check("R3 restart clears phase", v, 32'd7);
    @(negedge clk);
    rd(4'h4, v); check("R3 first step after restart", v, 32'd6);

    wr(4'h8, 32'h0);
    wr(4'h0, 32'd10);
    wr(4'h8, 32'h0701);
    repeat (5) @(negedge clk);
    wr(4'h8, 32'h0201);
    rd(4'h4, v); check("R12 no step before lowered prescale", v, 32'd10);
    @(negedge clk);
    rd(4'h4, v); check("R12 step after lowered prescale", v, 32'd9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule